// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block walks an instruction stream held in a halfword-wide instruction memory and turns it into decoded bundles, one instruction at a time. Each 16-bit opcode falls into one of three encoding forms, chosen by its two most significant bits. Register-form operations use one byte of operation code and two 4-bit register fields. Immediate-form operations carry a 2-bit operation, one register and an unsigned 8-bit immediate. Branch-form operations carry a 4-bit condition and a 10-bit halfword offset.

A fixed set of register-form operations is followed in memory by a 32-bit extension word. The decoder fetches the two extra halfwords and joins them before it presents the instruction. Encodings outside the defined set are still presented, but with an illegal flag and the address of the faulting opcode.

The execute stage takes bundles through a valid/ready handshake and can steer the fetch address at any time with a redirect. A redirect throws away any extension gathering that is in progress. The memory port gives read data one clock after a request.

Top module: `vlen_fetch_dec`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and the block requests the halfword at RESET_PC (imem_req=1, imem_addr=RESET_PC); the first bundle comes from that address.
- R2: An opcode with bit 15 = 0 is register form: out_form=0, out_op=bits 15:8, out_ra=bits 7:4, out_rb=bits 3:0, out_imm=0, out_boff=0.
- R3: An opcode with bits 15:14 = 10 is immediate form: out_form=1, out_op=bits 13:12 zero-extended, out_ra=bits 11:8, out_imm=bits 7:0, out_rb=0, out_boff=0.
- R4: An opcode with bits 15:14 = 11 is branch form: out_form=2, out_op=bits 13:10 zero-extended, out_boff=bits 9:0 sign-extended to 32 bits and doubled, out_ra=out_rb=out_imm=0, out_len=2.
- R5: Register-form operations 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 have out_len=6 and out_ext = {halfword at pc+2, halfword at pc+4}. Every other instruction has out_len=2 and out_ext=0.
- R6: Register-form operations 0x0F to 0x18 and 0x3A to 0x7F, and branch conditions 10 to 15, give out_illegal=1 with out_len=2, out_ext=0 and out_pc equal to the opcode's address. The fields are still extracted as in R2 and R4. All other encodings give out_illegal=0.
- R7: Bundles come out in program order. Each pc is the previous pc plus the previous length, modulo 2^ADDR_W (so gathering may wrap through address 0). out_valid drops in the cycle after a handshake.
- R8: While out_valid=1 and out_ready=0 with no redirect, out_valid stays 1 and every bundle field stays unchanged.
- R9: A redirect drops out_valid in the next cycle, discards any bundle or partly gathered extension, and makes the next bundle the instruction at redir_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Read request to instruction memory |
| imem_addr | output | ADDR_W | Byte address of the requested halfword |
| imem_rdata | input | 16 | Halfword returned one cycle after the request |
| redir_valid | input | 1 | Redirect fetch to redir_pc |
| redir_pc | input | ADDR_W | Redirect target (even byte address) |
| out_valid | output | 1 | Decoded bundle available |
| out_ready | input | 1 | Consumer accepts the bundle |
| out_form | output | 2 | 0 register, 1 immediate, 2 branch form |
| out_op | output | 8 | Operation or condition code |
| out_ra | output | 4 | First register field |
| out_rb | output | 4 | Second register field |
| out_imm | output | 8 | Unsigned 8-bit immediate |
| out_boff | output | 32 | Sign-extended byte branch offset |
| out_ext | output | 32 | Gathered 32-bit extension word |
| out_pc | output | ADDR_W | Address of the instruction |
| out_len | output | 3 | Instruction length in bytes, 2 or 6 |
| out_illegal | output | 1 | Encoding is not defined |

## Verification
The sweeps feed every register-form operation code, every immediate-form operation with all sixteen registers, and every branch condition with offsets at both ends of the signed range. A wrong length table would desynchronise the pc and turn extension words into opcodes. A mis-sign-extended offset would send large backward branches forward. A redirect that lands in the middle of extension gathering, and one that lands while a bundle is stalled, are checked for a stale bundle leaking out. An extension that straddles the top of the address space is checked for correct halfword order and for the wrapped next pc.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 32;
  localparam int OFF_W   = 10;
  localparam logic [3:0] LAST_COND = 4'd9;

  typedef enum logic [1:0] {
    FORM_REG = 2'd0,
    FORM_IMM = 2'd1,
    FORM_BR  = 2'd2
  } form_e;

  typedef struct packed {
    form_e              form;
    logic [7:0]         op;
    logic [3:0]         ra;
    logic [3:0]         rb;
    logic [7:0]         imm;
    logic [WORD_W-1:0]  boff;
    logic               wide;
    logic               bad;
  } dec_t;

  function automatic logic reg_form_defined(input logic [7:0] op);
    return (op <= 8'h0e) || ((op >= 8'h19) && (op <= 8'h39));
  endfunction

  function automatic logic reg_form_wide(input logic [7:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d,
      8'h1a, 8'h1b, 8'h1d, 8'h1f, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vfd_classify.sv
module vfd_classify
  import vfd_pkg::*;
(
  input  logic [HALF_W-1:0] word,
  output dec_t              dec,
  output logic              need_wide
);
  localparam int SEXT_W = WORD_W - OFF_W - 1;

  always_comb begin
    dec = dec_t'('0);
    if (!word[15]) begin
      dec.form = FORM_REG;
      dec.op   = word[15:8];
      dec.ra   = word[7:4];
      dec.rb   = word[3:0];
      dec.bad  = !reg_form_defined(word[15:8]);
      dec.wide = !dec.bad && reg_form_wide(word[15:8]);
    end else if (!word[14]) begin
      dec.form = FORM_IMM;
      dec.op   = {6'b0, word[13:12]};
      dec.ra   = word[11:8];
      dec.imm  = word[7:0];
    end else begin
      dec.form = FORM_BR;
      dec.op   = {4'b0, word[13:10]};
      dec.boff = {{SEXT_W{word[OFF_W-1]}}, word[OFF_W-1:0], 1'b0};
      dec.bad  = (word[13:10] > LAST_COND);
    end
    need_wide = dec.wide;
  end
endmodule

// File: rtl/vfd_seq.sv
module vfd_seq #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              out_ready,
  input  logic              need_wide,
  input  logic              held_wide,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  output logic [ADDR_W-1:0] cur_pc,
  output logic              ld_dec,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic              out_valid
);
  localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_HI      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_LO      = ADDR_W'(4);

  typedef enum logic [2:0] {S_REQ, S_OP, S_HI, S_LO, S_OUT} st_e;

  st_e               st;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] step;

  assign step      = held_wide ? STEP_WIDE : STEP_NARROW;
  assign cur_pc    = pc;
  assign out_valid = (st == S_OUT);

  always_comb begin
    imem_req  = 1'b0;
    imem_addr = pc;
    ld_dec    = 1'b0;
    ld_hi     = 1'b0;
    ld_lo     = 1'b0;
    if (!redir_valid) begin
      case (st)
        S_REQ: imem_req = 1'b1;
        S_OP: begin
          ld_dec = 1'b1;
          if (need_wide) begin
            imem_req  = 1'b1;
            imem_addr = pc + OFS_HI;
          end
        end
        S_HI: begin
          ld_hi     = 1'b1;
          imem_req  = 1'b1;
          imem_addr = pc + OFS_LO;
        end
        S_LO: ld_lo = 1'b1;
        S_OUT: if (out_ready) begin
          imem_req  = 1'b1;
          imem_addr = pc + step;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_REQ;
      pc <= RESET_PC;
    end else if (redir_valid) begin
      st <= S_REQ;
      pc <= redir_pc;
    end else begin
      case (st)
        S_REQ: st <= S_OP;
        S_OP:  st <= need_wide ? S_HI : S_OUT;
        S_HI:  st <= S_LO;
        S_LO:  st <= S_OUT;
        S_OUT: if (out_ready) begin
          st <= S_OP;
          pc <= pc + step;
        end
        default: st <= S_REQ;
      endcase
    end
  end

  assert_gather_order_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_HI && !redir_valid) |=> (st == S_LO || st == S_REQ));
endmodule

// File: rtl/vfd_hold.sv
module vfd_hold
  import vfd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_dec,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  dec_t              dec_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [HALF_W-1:0] half,
  output dec_t              dec_q,
  output logic [WORD_W-1:0] ext_q,
  output logic [ADDR_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= dec_t'('0);
      ext_q <= '0;
      pc_q  <= '0;
    end else begin
      if (ld_dec) begin
        dec_q <= dec_in;
        pc_q  <= pc_in;
        ext_q <= '0;
      end
      if (ld_hi) ext_q[WORD_W-1:HALF_W] <= half;
      if (ld_lo) ext_q[HALF_W-1:0]      <= half;
    end
  end
endmodule

// File: rtl/vlen_fetch_dec.sv
module vlen_fetch_dec
  import vfd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [15:0]       imem_rdata,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_form,
  output logic [7:0]        out_op,
  output logic [3:0]        out_ra,
  output logic [3:0]        out_rb,
  output logic [7:0]        out_imm,
  output logic [31:0]       out_boff,
  output logic [31:0]       out_ext,
  output logic [ADDR_W-1:0] out_pc,
  output logic [2:0]        out_len,
  output logic              out_illegal
);
  dec_t              dec_now;
  dec_t              dec_q;
  logic              need_wide;
  logic              ld_dec, ld_hi, ld_lo;
  logic [ADDR_W-1:0] cur_pc;

  vfd_classify u_cls (
    .word      (imem_rdata),
    .dec       (dec_now),
    .need_wide (need_wide)
  );

  vfd_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .out_ready   (out_ready),
    .need_wide   (need_wide),
    .held_wide   (dec_q.wide),
    .imem_req    (imem_req),
    .imem_addr   (imem_addr),
    .cur_pc      (cur_pc),
    .ld_dec      (ld_dec),
    .ld_hi       (ld_hi),
    .ld_lo       (ld_lo),
    .out_valid   (out_valid)
  );

  vfd_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .ld_dec (ld_dec),
    .ld_hi  (ld_hi),
    .ld_lo  (ld_lo),
    .dec_in (dec_now),
    .pc_in  (cur_pc),
    .half   (imem_rdata),
    .dec_q  (dec_q),
    .ext_q  (out_ext),
    .pc_q   (out_pc)
  );

  assign out_form    = dec_q.form;
  assign out_op      = dec_q.op;
  assign out_ra      = dec_q.ra;
  assign out_rb      = dec_q.rb;
  assign out_imm     = dec_q.imm;
  assign out_boff    = dec_q.boff;
  assign out_len     = dec_q.wide ? 3'd6 : 3'd2;
  assign out_illegal = dec_q.bad;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !redir_valid) |=>
      (out_valid && $stable({out_form, out_op, out_ra, out_rb, out_imm,
                             out_boff, out_ext, out_pc, out_len, out_illegal})));

  assert_len_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == 3'd6 || (out_len == 3'd2 && out_ext == '0)));

  assert_illegal_short_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_len == 3'd2));

  assert_branch_fields_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_form == 2'd2) |-> (out_len == 3'd2 && out_ra == 4'd0 && out_rb == 4'd0));

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !out_valid);

  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !redir_valid) |=> !out_valid);
endmodule

// File: tb/tb_vlen_fetch_dec.sv
module tb_vlen_fetch_dec;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          imem_req;
  logic [AW-1:0] imem_addr;
  logic [15:0]   imem_rdata;
  logic          redir_valid;
  logic [AW-1:0] redir_pc;
  logic          out_valid;
  logic          out_ready;
  logic [1:0]    out_form;
  logic [7:0]    out_op;
  logic [3:0]    out_ra, out_rb;
  logic [7:0]    out_imm;
  logic [31:0]   out_boff, out_ext;
  logic [AW-1:0] out_pc;
  logic [2:0]    out_len;
  logic          out_illegal;

  always #4 clk = ~clk;

  vlen_fetch_dec #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_form(out_form),
    .out_op(out_op), .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm),
    .out_boff(out_boff), .out_ext(out_ext), .out_pc(out_pc),
    .out_len(out_len), .out_illegal(out_illegal)
  );

  logic [15:0] mem [256];
  always @(posedge clk) if (imem_req) imem_rdata <= mem[imem_addr[8:1]];

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] epc;

  task automatic chk(input string tag, input logic [109:0] act, input logic [109:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic b_defined(input logic [7:0] op);
    return (op < 8'h0f) || (op > 8'h18 && op < 8'h3a);
  endfunction

  function automatic logic b_wide(input logic [7:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d, 8'h1a, 8'h1b, 8'h1d,
      8'h1f, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [109:0] model(input logic [AW-1:0] pc);
    logic [15:0] w;
    logic [AW-1:0] p2, p4;
    logic [1:0] f; logic [7:0] op, imm; logic [3:0] ra, rb;
    logic [31:0] boff, ext; logic bad, wide;
    w = mem[pc[8:1]];
    p2 = pc + 16'd2; p4 = pc + 16'd4;
    f = 0; op = 0; imm = 0; ra = 0; rb = 0; boff = 0; ext = 0; bad = 0; wide = 0;
    if (w[15] == 1'b0) begin
      f = 2'd0; op = w[15:8]; ra = w[7:4]; rb = w[3:0];
      bad = !b_defined(op);
      wide = !bad && b_wide(op);
      if (wide) ext = {mem[p2[8:1]], mem[p4[8:1]]};
    end else if (w[14] == 1'b0) begin
      f = 2'd1; op = {6'd0, w[13:12]}; ra = w[11:8]; imm = w[7:0];
    end else begin
      f = 2'd2; op = {4'd0, w[13:10]};
      boff = 32'(signed'(w[9:0])) * 2;
      bad = (w[13:10] >= 4'd10);
    end
    return {f, op, ra, rb, imm, boff, ext, pc, (wide ? 3'd6 : 3'd2), bad};
  endfunction

  function automatic logic [109:0] got();
    return {out_form, out_op, out_ra, out_rb, out_imm, out_boff, out_ext,
            out_pc, out_len, out_illegal};
  endfunction

  task automatic take(input int stall);
    logic [109:0] snap, exp;
    string tag;
    while (!out_valid) @(negedge clk);
    snap = got();
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R8 hold", {out_valid, got()}, {1'b1, snap});
    end
    exp = model(epc);
    if (exp[0]) tag = "R6 illegal";
    else if (exp[3:1] == 3'd6) tag = "R5 wide";
    else if (exp[109:108] == 2'd0) tag = "R2 reg form";
    else if (exp[109:108] == 2'd1) tag = "R3 imm form";
    else tag = "R4 branch form";
    chk(tag, snap, exp);
    chk("R7 pc", 110'(snap[19:4]), 110'(epc));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 valid drops", 110'(out_valid), 110'(0));
    epc = epc + AW'(exp[3:1]);
  endtask

  task automatic redirect(input logic [AW-1:0] t);
    @(negedge clk);
    redir_valid = 1'b1; redir_pc = t;
    @(negedge clk);
    redir_valid = 1'b0;
    chk("R9 flush", 110'(out_valid), 110'(0));
    epc = t;
  endtask

  function automatic logic [9:0] offs(input int k);
    case (k)
      0: return 10'h000; 1: return 10'h001; 2: return 10'h1ff; 3: return 10'h200;
      4: return 10'h3ff; 5: return 10'h155; 6: return 10'h2aa; default: return 10'h3fe;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    rst = 1'b1; redir_valid = 1'b0; redir_pc = '0; out_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    idx = 0;
    for (int op = 0; op < 128; op++) begin
      logic [7:0] o;
      o = 8'(op);
      mem[idx] = {o, o[3:0], ~o[3:0]}; idx++;
      if (b_defined(o) && b_wide(o)) begin
        mem[idx] = {o, 8'ha5}; idx++;
        mem[idx] = {8'h5a, ~o}; idx++;
      end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset request", 110'({imem_req, imem_addr, out_valid}), 110'({1'b1, 16'h0000, 1'b0}));
    epc = '0;
    for (int i = 0; i < 128; i++) take(i % 3);

    idx = 0;
    for (int op = 0; op < 4; op++)
      for (int r = 0; r < 16; r++) begin
        mem[idx] = {2'b10, 2'(op), 4'(r), 8'(r * 16 + op * 5 + 1)}; idx++;
      end
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 8; k++) begin
        mem[idx] = {2'b11, 4'(c), offs(k)}; idx++;
      end
    redirect(16'h0000);
    for (int i = 0; i < 192; i++) take(i % 2);

    mem[32] = 16'h0123; mem[33] = 16'hbeef; mem[34] = 16'hcafe;
    mem[64] = 16'h8a42; mem[65] = 16'h0000;
    redirect(16'h0040);
    @(negedge clk);
    redirect(16'h0080);
    take(0);
    redirect(16'h0040);
    while (!out_valid) @(negedge clk);
    redirect(16'h0080);
    take(1);

    mem[254] = 16'h1b70; mem[255] = 16'h1357; mem[0] = 16'h9abc; mem[1] = 16'h0000;
    redirect(16'hfffc);
    take(0);
    take(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule